// File: doc/BRIEF.md
# Command Stream Opcode Parser

This block takes a stream of 32-bit command words and splits it into headers and the payload words that belong to them. The top four bits of every header select an operation. The parser pulls out the class, register offset, mask, count and immediate fields and keeps track of how many of the following words are payload. It turns each payload word into a register-write event that carries a class, an offset and a data word. Immediate headers produce a write directly from the header.

Restart and gather headers are decoded and reported on a control-event port. The parser does not follow them and does not access memory. Lock acquire and release subcommands go out on a separate lock port.

The block accepts a word on every clock, so its ready output is always high. Each accepted word produces its results exactly one clock later, as single-cycle pulses. A last-word marker ends the stream. If the marker arrives while payload is still owed, the parser raises a truncation pulse and treats the next word as a header.

Top module: `cmd_parser`

## Requirements
- R1: The opcode is word bits 31:28. The decoded opcodes are 0 (set class), 1 (incrementing write), 2 (non-incrementing write), 3 (masked write), 4 (immediate), 5 (restart), 6 (gather) and 14 (extended). Any other opcode is a header with no payload and produces no write, event or lock pulse.
- R2: A set-class header loads the current class from bits 15:6. Bits 5:0 form a mask and bits 27:16 an offset. One payload word follows for each set mask bit. Set bit i writes offset+i with the new class, lowest bit first. A zero mask only changes the class.
- R3: An incrementing write takes its offset from bits 27:16 and its payload count from bits 15:0. Payload word k goes to offset+k, and the offset wraps within 12 bits. A count of zero means no payload.
- R4: A non-incrementing write has the same format as R3, but every payload word goes to the header's offset.
- R5: A masked write takes its offset from bits 27:16 and a 16-bit mask from bits 15:0. One payload word follows per set bit. Set bit i writes offset+i, lowest bit first.
- R6: An immediate header produces one write to the offset in bits 27:16. The data is bits 15:0 zero-extended, and the class is the current class. No payload follows.
- R7: A restart header produces a control event of kind 0 whose address is the header shifted left by 4. No payload follows.
- R8: A gather header is followed by exactly one address word. That word produces a control event of kind 1 with the address word, offset bits 27:16, insert flag bit 15, type flag bit 14 and count bits 13:0, all taken from the header.
- R9: An extended header takes its subcommand from bits 27:24 and its index from bits 7:0. Subcommand 0 pulses the lock port with release=0 and subcommand 1 with release=1, each carrying the index. Any other subcommand produces a control event of kind 2 whose address is the raw header.
- R10: If the last-word marker is accepted and payload is still owed after that word, a truncation pulse is raised. The next word is then decoded as a header. A last word that leaves nothing owed raises no truncation.
- R11: in_ready is always 1. Every output pulse appears in the cycle after the word that caused it and lasts one cycle. Idle cycles produce no pulses and do not disturb payload tracking. After reset, all pulses are low and the class is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_word | input | 32 | Command word |
| in_last | input | 1 | Word is the last of the stream |
| in_ready | output | 1 | Word accepted (always 1) |
| wr_valid | output | 1 | Register-write pulse |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Data of the write |
| ev_valid | output | 1 | Control-event pulse |
| ev_kind | output | 2 | 0 restart, 1 gather, 2 unknown extended |
| ev_addr | output | 32 | Restart target, gather address or raw header |
| ev_offset | output | 12 | Gather offset |
| ev_insert | output | 1 | Gather insert flag |
| ev_type | output | 1 | Gather type flag |
| ev_count | output | 14 | Gather count |
| lock_valid | output | 1 | Lock subcommand pulse |
| lock_release | output | 1 | 0 acquire, 1 release |
| lock_index | output | 8 | Lock index |
| trunc | output | 1 | Stream ended with payload owed |

## Verification
A register write and a truncation pulse can appear in the same cycle. This happens when the last-word marker lands on a payload word that does not finish its header: the word must still be written while truncation is flagged. The bench provokes this mid-way through incrementing and masked payloads. It also places the marker on headers that owe payload and on headers that owe none. A behavioural reference model predicts every output each clock and judges both pulses together, along with the header decode that follows.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    typedef enum logic [2:0] {
        M_HDR    = 3'd0,
        M_INC    = 3'd1,
        M_NONINC = 3'd2,
        M_MSK    = 3'd3,
        M_GADDR  = 3'd4
    } mode_e;

    localparam logic [3:0] OP_SETCL  = 4'h0;
    localparam logic [3:0] OP_INCR   = 4'h1;
    localparam logic [3:0] OP_NONINC = 4'h2;
    localparam logic [3:0] OP_MASK   = 4'h3;
    localparam logic [3:0] OP_IMM    = 4'h4;
    localparam logic [3:0] OP_RESTRT = 4'h5;
    localparam logic [3:0] OP_GATHER = 4'h6;
    localparam logic [3:0] OP_EXT    = 4'he;

    localparam logic [3:0] SUB_ACQ = 4'h0;
    localparam logic [3:0] SUB_REL = 4'h1;

    localparam logic [1:0] EV_RESTART = 2'd0;
    localparam logic [1:0] EV_GATHER  = 2'd1;
    localparam logic [1:0] EV_EXTUNK  = 2'd2;

    localparam int CLS_W  = 10;
    localparam int OFS_W  = 12;
    localparam int FLD_W  = 16;
    localparam int GCNT_W = 14;

    typedef struct packed {
        logic [3:0]        op;
        logic [CLS_W-1:0]  cls;
        logic [OFS_W-1:0]  offs;
        logic [FLD_W-1:0]  low;
        logic [3:0]        subop;
        logic [7:0]        idx;
        logic              ins;
        logic              gtyp;
        logic [GCNT_W-1:0] gcnt;
    } hdr_t;

endpackage

// File: rtl/cmdp_hdr_dec.sv
module cmdp_hdr_dec
    import cmdp_pkg::*;
(
    input  logic [31:0] word,
    output hdr_t        hdr
);
    always_comb begin
        hdr.op    = word[31:28];
        hdr.offs  = word[27:16];
        hdr.cls   = word[15:6];
        hdr.low   = word[15:0];
        hdr.subop = word[27:24];
        hdr.idx   = word[7:0];
        hdr.ins   = word[15];
        hdr.gtyp  = word[14];
        hdr.gcnt  = word[13:0];
    end
endmodule

// File: rtl/cmdp_lowbit.sv
module cmdp_lowbit #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);
    logic [W-1:0] below;
    logic [W-1:0] first;

    assign below[0] = 1'b0;
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign below[i] = below[i-1] | mask[i-1];
    end
    assign first = mask & ~below;
    assign rest  = mask & ~first;

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
    import cmdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    input  logic        in_last,
    output logic        in_ready,
    output logic        wr_valid,
    output logic [9:0]  wr_class,
    output logic [11:0] wr_offset,
    output logic [31:0] wr_data,
    output logic        ev_valid,
    output logic [1:0]  ev_kind,
    output logic [31:0] ev_addr,
    output logic [11:0] ev_offset,
    output logic        ev_insert,
    output logic        ev_type,
    output logic [13:0] ev_count,
    output logic        lock_valid,
    output logic        lock_release,
    output logic [7:0]  lock_index,
    output logic        trunc
);
    localparam int MIW = $clog2(FLD_W);

    typedef struct packed {
        mode_e             mode;
        logic [CLS_W-1:0]  cls;
        logic [OFS_W-1:0]  offs;
        logic [FLD_W-1:0]  cnt;
        logic [FLD_W-1:0]  mask;
        logic [OFS_W-1:0]  g_offs;
        logic              g_ins;
        logic              g_typ;
        logic [GCNT_W-1:0] g_cnt;
        logic              wr_v;
        logic [CLS_W-1:0]  wr_c;
        logic [OFS_W-1:0]  wr_o;
        logic [31:0]       wr_dat;
        logic              ev_v;
        logic [1:0]        ev_k;
        logic [31:0]       ev_a;
        logic [OFS_W-1:0]  ev_o;
        logic              ev_i;
        logic              ev_t;
        logic [GCNT_W-1:0] ev_c;
        logic              lk_v;
        logic              lk_r;
        logic [7:0]        lk_i;
        logic              tr;
    } st_t;

    st_t  st_d, st_q;
    hdr_t hdr;
    logic [MIW-1:0]   bit_idx;
    logic [FLD_W-1:0] mask_rest;

    cmdp_hdr_dec u_dec (
        .word (in_word),
        .hdr  (hdr)
    );

    cmdp_lowbit #(.W(FLD_W)) u_low (
        .mask (st_q.mask),
        .idx  (bit_idx),
        .rest (mask_rest)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wr_v = 1'b0;
        st_d.ev_v = 1'b0;
        st_d.lk_v = 1'b0;
        st_d.tr   = 1'b0;
        if (in_valid) begin
            case (st_q.mode)
                M_HDR: begin
                    case (hdr.op)
                        OP_SETCL: begin
                            st_d.cls  = hdr.cls;
                            st_d.offs = hdr.offs;
                            st_d.mask = {10'b0, hdr.low[5:0]};
                            st_d.mode = (hdr.low[5:0] != 6'd0) ? M_MSK : M_HDR;
                        end
                        OP_INCR, OP_NONINC: begin
                            st_d.offs = hdr.offs;
                            st_d.cnt  = hdr.low;
                            if (hdr.low == '0)          st_d.mode = M_HDR;
                            else if (hdr.op == OP_INCR) st_d.mode = M_INC;
                            else                        st_d.mode = M_NONINC;
                        end
                        OP_MASK: begin
                            st_d.offs = hdr.offs;
                            st_d.mask = hdr.low;
                            st_d.mode = (hdr.low != '0) ? M_MSK : M_HDR;
                        end
                        OP_IMM: begin
                            st_d.wr_v   = 1'b1;
                            st_d.wr_c   = st_q.cls;
                            st_d.wr_o   = hdr.offs;
                            st_d.wr_dat = {16'b0, hdr.low};
                        end
                        OP_RESTRT: begin
                            st_d.ev_v = 1'b1;
                            st_d.ev_k = EV_RESTART;
                            st_d.ev_a = {in_word[27:0], 4'b0};
                        end
                        OP_GATHER: begin
                            st_d.g_offs = hdr.offs;
                            st_d.g_ins  = hdr.ins;
                            st_d.g_typ  = hdr.gtyp;
                            st_d.g_cnt  = hdr.gcnt;
                            st_d.mode   = M_GADDR;
                        end
                        OP_EXT: begin
                            if (hdr.subop == SUB_ACQ || hdr.subop == SUB_REL) begin
                                st_d.lk_v = 1'b1;
                                st_d.lk_r = (hdr.subop == SUB_REL);
                                st_d.lk_i = hdr.idx;
                            end else begin
                                st_d.ev_v = 1'b1;
                                st_d.ev_k = EV_EXTUNK;
                                st_d.ev_a = in_word;
                            end
                        end
                        default: ;
                    endcase
                end
                M_INC, M_NONINC: begin
                    st_d.wr_v   = 1'b1;
                    st_d.wr_c   = st_q.cls;
                    st_d.wr_o   = st_q.offs;
                    st_d.wr_dat = in_word;
                    if (st_q.mode == M_INC) st_d.offs = st_q.offs + 1'b1;
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_q.cnt == FLD_W'(1)) st_d.mode = M_HDR;
                end
                M_MSK: begin
                    st_d.wr_v   = 1'b1;
                    st_d.wr_c   = st_q.cls;
                    st_d.wr_o   = st_q.offs + OFS_W'(bit_idx);
                    st_d.wr_dat = in_word;
                    st_d.mask   = mask_rest;
                    if (mask_rest == '0) st_d.mode = M_HDR;
                end
                M_GADDR: begin
                    st_d.ev_v = 1'b1;
                    st_d.ev_k = EV_GATHER;
                    st_d.ev_a = in_word;
                    st_d.ev_o = st_q.g_offs;
                    st_d.ev_i = st_q.g_ins;
                    st_d.ev_t = st_q.g_typ;
                    st_d.ev_c = st_q.g_cnt;
                    st_d.mode = M_HDR;
                end
                default: st_d.mode = M_HDR;
            endcase
            if (in_last && st_d.mode != M_HDR) begin
                st_d.tr   = 1'b1;
                st_d.mode = M_HDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready     = 1'b1;
    assign wr_valid     = st_q.wr_v;
    assign wr_class     = st_q.wr_c;
    assign wr_offset    = st_q.wr_o;
    assign wr_data      = st_q.wr_dat;
    assign ev_valid     = st_q.ev_v;
    assign ev_kind      = st_q.ev_k;
    assign ev_addr      = st_q.ev_a;
    assign ev_offset    = st_q.ev_o;
    assign ev_insert    = st_q.ev_i;
    assign ev_type      = st_q.ev_t;
    assign ev_count     = st_q.ev_c;
    assign lock_valid   = st_q.lk_v;
    assign lock_release = st_q.lk_r;
    assign lock_index   = st_q.lk_i;
    assign trunc        = st_q.tr;

    // R11: pulses only follow an accepted word
    a_r11_pulse_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || ev_valid || lock_valid || trunc) |-> $past(in_valid));

    // R11: one word yields at most one of write, event or lock
    a_r11_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, ev_valid, lock_valid}));

    // R10: truncation only after an accepted last word
    a_r10_trunc_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        trunc |-> $past(in_valid && in_last));

    // R5: masked-payload mode always owes at least one word
    a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_MSK) |-> (st_q.mask != '0));

    // R7: restart target is word aligned to 16
    a_r7_restart_align: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_RESTART) |-> (ev_addr[3:0] == 4'h0));

    // R9: lock pulse only after an extended header
    a_r9_lock_from_ext: assert property (@(posedge clk) disable iff (!rst_n)
        lock_valid |-> ($past(in_word[31:28]) == OP_EXT));

    // R3: payload tracking is frozen on idle cycles
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.cnt) && $stable(st_q.mode));
endmodule

// File: tb/cmd_parser_bench.sv
module cmd_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_last = 1'b0;
    logic        in_ready, wr_valid, ev_valid, ev_insert, ev_type;
    logic        lock_valid, lock_release, trunc;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset, ev_offset;
    logic [31:0] wr_data, ev_addr;
    logic [1:0]  ev_kind;
    logic [13:0] ev_count;
    logic [7:0]  lock_index;

    always #5 clk = ~clk;

    cmd_parser u_cmd_parser (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int m_mode = 0;   // 0 header, 1 incr, 2 nonincr, 3 mask, 4 gather address
    int m_cls = 0, m_offs = 0, m_cnt = 0;
    int m_mask = 0, g_offs = 0, g_ins = 0, g_typ = 0, g_cnt = 0;
    // expected pulses
    bit  e_wr, e_ev, e_lk, e_tr;
    int  e_cls, e_offs, e_kind, e_eo, e_ei, e_et, e_ec, e_rel, e_idx;
    logic [31:0] e_data, e_addr;
    string tag = "R11";

    task automatic check(input bit ok, input string t, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic model(input bit v, input logic [31:0] w, input bit last);
        int op;
        e_wr = 0; e_ev = 0; e_lk = 0; e_tr = 0;
        if (!v) return;
        op = int'(w[31:28]);
        if (m_mode == 0) begin
            if (op == 0) begin
                m_cls = int'(w[15:6]); m_offs = int'(w[27:16]);
                m_mask = int'(w[5:0]); m_mode = (m_mask != 0) ? 3 : 0;
            end else if (op == 1 || op == 2) begin
                m_offs = int'(w[27:16]); m_cnt = int'(w[15:0]);
                m_mode = (m_cnt == 0) ? 0 : op;
            end else if (op == 3) begin
                m_offs = int'(w[27:16]); m_mask = int'(w[15:0]);
                m_mode = (m_mask != 0) ? 3 : 0;
            end else if (op == 4) begin
                e_wr = 1; e_cls = m_cls; e_offs = int'(w[27:16]);
                e_data = {16'h0, w[15:0]};
            end else if (op == 5) begin
                e_ev = 1; e_kind = 0; e_addr = w << 4;
            end else if (op == 6) begin
                g_offs = int'(w[27:16]); g_ins = int'(w[15]); g_typ = int'(w[14]);
                g_cnt = int'(w[13:0]); m_mode = 4;
            end else if (op == 14) begin
                if (w[27:24] <= 4'd1) begin
                    e_lk = 1; e_rel = int'(w[24]); e_idx = int'(w[7:0]);
                end else begin
                    e_ev = 1; e_kind = 2; e_addr = w;
                end
            end
        end else if (m_mode == 1 || m_mode == 2) begin
            e_wr = 1; e_cls = m_cls; e_offs = m_offs; e_data = w;
            if (m_mode == 1) m_offs = (m_offs + 1) % 4096;
            m_cnt--;
            if (m_cnt == 0) m_mode = 0;
        end else if (m_mode == 3) begin
            int i = 0;
            while (((m_mask >> i) & 1) == 0) i++;
            e_wr = 1; e_cls = m_cls; e_offs = (m_offs + i) % 4096; e_data = w;
            m_mask = m_mask & ~(1 << i);
            if (m_mask == 0) m_mode = 0;
        end else begin
            e_ev = 1; e_kind = 1; e_addr = w; e_eo = g_offs;
            e_ei = g_ins; e_et = g_typ; e_ec = g_cnt; m_mode = 0;
        end
        if (last && m_mode != 0) begin
            e_tr = 1; m_mode = 0;
        end
    endtask

    task automatic step(input bit v, input logic [31:0] w, input bit last = 0);
        @(negedge clk);
        in_valid = v; in_word = w; in_last = last;
        model(v, w, last);
        @(posedge clk);
        #2;
        check(wr_valid == e_wr, tag, "wr_valid", wr_valid, e_wr);
        if (e_wr && wr_valid)
            check(wr_class == e_cls[9:0] && wr_offset == e_offs[11:0] && wr_data == e_data,
                  tag, "write cls/off/data", {wr_class, wr_offset, wr_data},
                  {e_cls[9:0], e_offs[11:0], e_data});
        check(ev_valid == e_ev, tag, "ev_valid", ev_valid, e_ev);
        if (e_ev && ev_valid) begin
            check(ev_kind == e_kind[1:0] && ev_addr == e_addr, tag, "event kind/addr",
                  {ev_kind, ev_addr}, {e_kind[1:0], e_addr});
            if (e_kind == 1)
                check(ev_offset == e_eo[11:0] && ev_insert == e_ei[0] && ev_type == e_et[0]
                      && ev_count == e_ec[13:0], tag, "gather fields",
                      {ev_offset, ev_insert, ev_type, ev_count},
                      {e_eo[11:0], e_ei[0], e_et[0], e_ec[13:0]});
        end
        check(lock_valid == e_lk, tag, "lock_valid", lock_valid, e_lk);
        if (e_lk && lock_valid)
            check(lock_release == e_rel[0] && lock_index == e_idx[7:0], tag, "lock fields",
                  {lock_release, lock_index}, {e_rel[0], e_idx[7:0]});
        check(trunc == e_tr, tag, "trunc", trunc, e_tr);
        check(in_ready == 1'b1, "R11", "in_ready", in_ready, 1);
    endtask

    function automatic logic [31:0] hw(input int op, input int ofs, input int low);
        return {op[3:0], ofs[11:0], low[15:0]};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        tag = "R11";
        check(!wr_valid && !ev_valid && !lock_valid && !trunc, "R11", "reset pulses",
              {wr_valid, ev_valid, lock_valid, trunc}, 0);
        @(negedge clk); rst_n = 1'b1;
        // R6 immediate with reset class 0
        tag = "R6";  step(1, hw(4, 12'h123, 16'hBEEF));
        // R2 set class with mask 100101, then zero mask
        tag = "R2";  step(1, {4'h0, 12'h010, 10'h155, 6'b100101});
        step(1, 32'hA0); step(0, 0); step(1, 32'hA1); step(1, 32'hA2);
        step(1, {4'h0, 12'h777, 10'h2AA, 6'b0});
        tag = "R6";  step(1, hw(4, 12'h004, 16'h0055));
        // R3 incrementing write with 12-bit wrap
        tag = "R3";  step(1, hw(1, 12'hFFE, 3));
        step(1, 32'h11); step(1, 32'h12); step(0, 0); step(1, 32'h13);
        step(1, hw(1, 12'h100, 0));
        // R4 non-incrementing
        tag = "R4";  step(1, hw(2, 12'h040, 2)); step(1, 32'h21); step(1, 32'h22);
        // R5 masked write, high and low bits
        tag = "R5";  step(1, hw(3, 12'h200, 16'h8001)); step(1, 32'h31); step(1, 32'h32);
        step(1, hw(3, 12'h300, 16'hFFFF));
        for (int i = 0; i < 16; i++) step(1, 32'h400 + i);
        // R7 restart
        tag = "R7";  step(1, 32'h5123_4567);
        // R8 gather then address word
        tag = "R8";  step(1, {4'h6, 12'h0AB, 1'b1, 1'b0, 14'h1234}); step(1, 32'hDEAD_BEE0);
        step(1, {4'h6, 12'h0CD, 1'b0, 1'b1, 14'h0005}); step(1, 32'h0000_1000);
        // R9 lock acquire, release, unknown
        tag = "R9";  step(1, 32'hE000_0007); step(1, 32'hE100_00FE); step(1, 32'hE500_0033);
        // R1 unlisted opcodes
        tag = "R1";  step(1, 32'h7FFF_FFFF); step(1, 32'hF000_0001); step(1, 32'h8123_0004);
        // R10 truncation with concurrent write
        tag = "R10"; step(1, hw(1, 12'h050, 5)); step(1, 32'h61); step(1, 32'h62, 1);
        step(1, hw(4, 12'h051, 16'h0001));
        step(1, hw(3, 12'h060, 16'h0007)); step(1, 32'h71, 1);
        step(1, hw(2, 12'h070, 4), 1);
        step(1, hw(6, 12'h001, 16'h0002), 1);
        step(1, hw(4, 12'h072, 16'h0009), 1);
        step(1, hw(1, 12'h080, 1)); step(1, 32'h81, 1);
        // mixed random stream
        tag = "R11";
        for (int n = 0; n < 600; n++) begin
            logic [31:0] w = $urandom;
            if (w[31:28] inside {4'h1, 4'h2}) w[15:3] = '0;
            step(($urandom % 5) != 0, w, ($urandom % 20) == 0);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule